// File: doc/BRIEF.md
# Write-Protect Chip-Enable Gate

This block sits on the active-low chip-enable path between a host and a battery-backed static memory. It takes the host's chip-enable and a synchronous supply-fault flag, which already carries the decision of an analog supply comparator, and drives a conditioned chip-enable toward the memory. While the supply is good the memory sees the host's enable. When the supply fails, new accesses are blocked at once. An access that is already running may finish, but only within a bounded write-protect window, after which the memory is deselected regardless. When the supply comes back, the memory stays deselected for a recovery period so the host can settle.

Both inputs pass through a two-flop synchronizer, so the host enable reaches the memory two clock cycles after it changes. A four-state machine decides the output. PASS forwards the enable. DRAIN lets a running access finish under a timeout. PROTECT holds the memory deselected for as long as the fault lasts. RECOVER holds it deselected for the recovery time after the fault ends. Reset enters RECOVER. The transitions are:
- PASS→DRAIN: fault while the enable is active.
- PASS→PROTECT: fault while the enable is inactive.
- DRAIN→PROTECT: the enable returns high, or the write-protect window expires.
- PROTECT→RECOVER: the fault clears.
- RECOVER→PROTECT: a new fault arrives.
- RECOVER→PASS: the recovery time has elapsed and the host enable is high.

A single down-counter serves as the timer for both windows. It is loaded each time DRAIN or RECOVER is entered. Both windows are counted in clock cycles and set by parameters: `WP_CYCLES` for the write-protect window and `REC_CYCLES` for the recovery time.

Top module: `ce_gate_wp`

## Requirements
- R1: During reset and afterwards, `mem_ce_n` is 1. After reset is released, it stays 1 for at least `REC_CYCLES` cycles whatever `host_ce_n` does.
- R2: In PASS, `mem_ce_n` equals `host_ce_n` delayed by exactly two clock cycles, including for single-cycle pulses.
- R3: If the fault flag is raised while the synchronized host enable is 1 (inactive), the gate enters PROTECT. A host enable that falls afterwards is not passed through.
- R4: If the fault flag is raised while the synchronized host enable is 0, the gate enters DRAIN and the output keeps following the host. Once the host enable returns to 1, the output goes to 1 and stays 1 for the rest of the fault.
- R5: If the host enable is still 0 after `WP_CYCLES` cycles in DRAIN, the output is forced to 1. Driving the fault at a falling edge n (with the enable low) gives 0 at falling edge n+2+WP_CYCLES and 1 at n+3+WP_CYCLES.
- R6: Once the output is 1 during a fault, it stays 1 until the fault clears, whatever the host enable does.
- R7: When the fault clears, the gate enters RECOVER and holds the output at 1 for `REC_CYCLES` cycles, ignoring the host. Clearing the fault at falling edge k (with the host enable high) lets a host enable driven low at k+REC_CYCLES+1 appear as 0 at k+REC_CYCLES+3. A fault raised during RECOVER returns the gate to PROTECT, and the full recovery time restarts when that fault clears.
- R8: If the synchronized host enable is 0 when the recovery time ends, the gate stays in RECOVER until the host enable has been 1. It then enters PASS, so no partial access reaches the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all windows count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset; enters RECOVER |
| host_ce_n | input | 1 | Host chip-enable, active low |
| supply_fault | input | 1 | 1 while the supply is out of tolerance |
| mem_ce_n | output | 1 | Conditioned chip-enable toward the memory, active low |

## Verification
The host enable is driven as long low phases, as single-cycle pulses and as toggles, each with the supply steady, during a fault and during recovery. This separates the two-cycle pass latency from any blocking. A fault is raised once with the enable idle and once with it active. The active case is run twice: once with the access ending early and once with it outliving the window, which shows that the timeout fires at exactly its cycle count. The enable is also placed one cycle either side of the end of recovery, and a fault is raised again mid-recovery. Together these confirm the release edge, the partial-access guard and the restart of the recovery timer.

// File: rtl/ce_gate_pkg.sv
package ce_gate_pkg;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROTECT = 2'd2,
        ST_RECOVER = 2'd3
    } gate_state_e;

endpackage

// File: rtl/ce_gate_sync.sv
module ce_gate_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ce_gate_timer.sv
module ce_gate_timer #(
    parameter int TW        = 8,
    parameter int RST_COUNT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    localparam logic [TW-1:0] RST_LOAD = TW'(RST_COUNT);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RST_LOAD;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/ce_gate_wp.sv
module ce_gate_wp
    import ce_gate_pkg::*;
#(
    parameter int WP_CYCLES  = 200,
    parameter int REC_CYCLES = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_ce_n,
    input  logic supply_fault,
    output logic mem_ce_n
);
    localparam int MAXC = (WP_CYCLES > REC_CYCLES) ? WP_CYCLES : REC_CYCLES;
    localparam int TW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

    localparam logic [TW-1:0] WP_LOAD  = TW'(WP_CYCLES - 1);
    localparam logic [TW-1:0] REC_LOAD = TW'(REC_CYCLES - 1);

    initial begin
        if (WP_CYCLES < 1 || REC_CYCLES < 1)
            $error("ce_gate_wp: window parameters must be at least 1");
    end

    // Synchronized inputs: bit 0 host enable (resets inactive), bit 1 fault
    logic [1:0] sync_q;
    logic       ce_s;
    logic       flt_s;

    ce_gate_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({supply_fault, host_ce_n}),
        .q     (sync_q)
    );

    assign ce_s  = sync_q[0];
    assign flt_s = sync_q[1];

    gate_state_e   state_q, state_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;

    ce_gate_timer #(.TW(TW), .RST_COUNT(REC_CYCLES - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: begin
                if (flt_s)
                    state_d = ce_s ? ST_PROTECT : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ce_s || tmr_done)
                    state_d = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!flt_s)
                    state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (flt_s)
                    state_d = ST_PROTECT;
                else if (tmr_done && ce_s)
                    state_d = ST_PASS;
            end
            default: state_d = ST_RECOVER;
        endcase
    end

    // Timer reload on entry into a timed state
    always_comb begin
        tmr_load = (state_d != state_q) &&
                   ((state_d == ST_DRAIN) || (state_d == ST_RECOVER));
        tmr_val  = (state_d == ST_DRAIN) ? WP_LOAD : REC_LOAD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RECOVER;
        else
            state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_PASS, ST_DRAIN:      mem_ce_n = ce_s;
            ST_PROTECT, ST_RECOVER: mem_ce_n = 1'b1;
            default:                mem_ce_n = 1'b1;
        endcase
    end

    // Observation counters for the window properties below
    localparam logic [TW:0] LOW_LIMIT = (TW+1)'(WP_CYCLES + 1);
    localparam logic [TW:0] REC_LIMIT = (TW+1)'(REC_CYCLES);

    logic [TW:0] fault_low_cnt;
    logic [TW:0] rec_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_low_cnt <= '0;
            rec_age       <= '0;
        end else begin
            if (!flt_s)
                fault_low_cnt <= '0;
            else if (!mem_ce_n && fault_low_cnt <= LOW_LIMIT)
                fault_low_cnt <= fault_low_cnt + 1'b1;

            if (state_q != ST_RECOVER)
                rec_age <= '0;
            else if (rec_age < REC_LIMIT)
                rec_age <= rec_age + 1'b1;
        end
    end

    AST_FAULT_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_s && mem_ce_n) |=> mem_ce_n); // R6

    AST_DRAIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fault_low_cnt <= LOW_LIMIT); // R5

    AST_RELEASE_HOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && $past(state_q) == ST_RECOVER) |-> $past(ce_s)); // R8

    AST_RECOVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && $past(state_q) == ST_RECOVER) |-> rec_age >= REC_LIMIT); // R7

endmodule

// File: tb/ce_gate_wp_test.sv
module ce_gate_wp_test;
    localparam int CLK_PERIOD = 10;
    localparam int WP  = 6;
    localparam int REC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_ce_n = 1'b1;
    logic supply_fault = 1'b0;
    logic mem_ce_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ce_gate_wp #(.WP_CYCLES(WP), .REC_CYCLES(REC)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_ce_n    (host_ce_n),
        .supply_fault (supply_fault),
        .mem_ce_n     (mem_ce_n)
    );

    // Scoreboard: expected output per falling-edge index
    int    qc[$];
    bit    qv[$];
    string qt[$];
    int    now = 0;
    int    mcyc = 0;
    int    tests = 0;
    int    fails = 0;
    bit    done = 0;

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            now++;
        end
    endtask

    task automatic expect_at(int d, bit v, string tag);
        qc.push_back(now + d);
        qv.push_back(v);
        qt.push_back(tag);
    endtask

    // Monitor
    always @(negedge clk) begin
        mcyc++;
        for (int i = qc.size() - 1; i >= 0; i--) begin
            if (qc[i] == mcyc) begin
                tests++;
                if (mem_ce_n !== qv[i]) begin
                    fails++;
                    $display("FAIL %s at cycle %0d: mem_ce_n=%b expected %b",
                             qt[i], mcyc, mem_ce_n, qv[i]);
                end
                qc.delete(i);
                qv.delete(i);
                qt.delete(i);
            end
        end
    end

    // Driver
    initial begin
        expect_at(1, 1'b1, "R1");
        expect_at(2, 1'b1, "R1");
        tick(3);
        rst_n = 1'b1;
        host_ce_n = 1'b0;
        expect_at(REC - 1, 1'b1, "R1");
        expect_at(REC + 5, 1'b1, "R8");
        tick(REC + 6);
        host_ce_n = 1'b1;
        tick(4);

        // R2: low phase, then high
        host_ce_n = 1'b0;
        expect_at(1, 1'b1, "R2");
        expect_at(2, 1'b0, "R2");
        tick(3);
        host_ce_n = 1'b1;
        expect_at(1, 1'b0, "R2");
        expect_at(2, 1'b1, "R2");
        tick(3);
        // R2: single-cycle pulse
        host_ce_n = 1'b0;
        tick(1);
        host_ce_n = 1'b1;
        expect_at(1, 1'b0, "R2");
        expect_at(2, 1'b1, "R2");
        tick(4);

        // R3 / R6: fault with idle host, then host toggles
        supply_fault = 1'b1;
        tick(1);
        host_ce_n = 1'b0;
        expect_at(2, 1'b1, "R3");
        tick(2);
        host_ce_n = 1'b1;
        tick(2);
        host_ce_n = 1'b0;
        expect_at(3, 1'b1, "R6");
        tick(4);
        host_ce_n = 1'b1;
        tick(3);

        // R7: recovery ignores host, releases on the exact cycle
        supply_fault = 1'b0;
        tick(5);
        host_ce_n = 1'b0;
        expect_at(3, 1'b1, "R7");
        tick(3);
        host_ce_n = 1'b1;
        tick(REC - 7);
        host_ce_n = 1'b0;
        expect_at(1, 1'b1, "R7");
        expect_at(2, 1'b0, "R7");
        tick(4);
        host_ce_n = 1'b1;
        tick(4);

        // R4: access ends early inside the window
        host_ce_n = 1'b0;
        tick(4);
        supply_fault = 1'b1;
        tick(3);
        host_ce_n = 1'b1;
        expect_at(1, 1'b0, "R4");
        expect_at(2, 1'b1, "R4");
        tick(3);
        host_ce_n = 1'b0;
        expect_at(3, 1'b1, "R4");
        tick(5);
        host_ce_n = 1'b1;
        tick(2);
        supply_fault = 1'b0;
        tick(REC + 6);

        // R5: access outlives the window
        host_ce_n = 1'b0;
        tick(4);
        supply_fault = 1'b1;
        expect_at(2 + WP, 1'b0, "R5");
        expect_at(3 + WP, 1'b1, "R5");
        tick(WP + 6);
        host_ce_n = 1'b1;
        tick(2);
        host_ce_n = 1'b0;
        expect_at(3, 1'b1, "R6");
        tick(4);
        host_ce_n = 1'b1;
        tick(2);

        // R7: fault again mid-recovery restarts the recovery time
        supply_fault = 1'b0;
        tick(5);
        supply_fault = 1'b1;
        tick(5);
        supply_fault = 1'b0;
        tick(REC - 6);
        host_ce_n = 1'b0;
        expect_at(3, 1'b1, "R7");
        tick(4);
        host_ce_n = 1'b1;
        tick(10);
        host_ce_n = 1'b0;
        expect_at(2, 1'b0, "R2");
        tick(4);

        tick(2);
        if (qc.size() != 0) begin
            fails++;
            $display("FAIL R1 scoreboard: %0d expectations unchecked, expected 0", qc.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (2000) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule